// File: doc/BRIEF.md
# Host Message and Doorbell Register File

This block is a small device-side register file that a host processor reaches over a plain 32-bit memory-mapped bus. It carries four 32-bit mailbox words, two written mainly by the host and two written mainly by the device. It also has a pair of doorbells with their own interrupt masks and masked-status views. The host signals the device by setting bits in the inbound doorbell. Device logic clears those bits with a one-cycle strobe once it has acted on them. In the other direction, device logic raises bits in the outbound doorbell through a local set port. Any unmasked outbound bit drives the host interrupt line. The host acknowledges by writing back the value it read, and each 1 in that write clears the matching bit.

The local side sees all four mailbox words at all times and may overwrite any of them. When both sides write the same word in the same cycle, the local value is kept. Host reads are registered: the data for a read strobe appears on the cycle after it. The bus has no wait states, so a read issued right after a write always returns the updated value, and the read acts as a flush of that write.

Inbound doorbell bit meanings: bit 0 handshake request, bit 1 new requests queued, bit 2 completions consumed, bit 3 host has stopped, bit 4 device reset request. Outbound doorbell bit meanings: bit 0 handshake reply, bit 1 requests consumed, bit 2 new completions posted, bit 3 attached bus changed, bit 4 event pending.

Top module: `hostmsg_regfile`

## Requirements
- R1: After synchronous reset the following are zero: all mailbox words, both doorbells, `h_rdata`, `host_irq` and `lc_irq`. Both mask registers read as all ones in their NBELL low bits, which means every bit is masked.
- R2: The host reads and writes the mailbox words at byte offsets 0x10, 0x14, 0x18 and 0x1C. Address bits [1:0] are ignored. A read strobe in one cycle returns data on `h_rdata` in the next cycle, and that data includes a write made in the previous cycle. `lc_msg_rdata` shows the words as [31:0]=0x10, [63:32]=0x14, [95:64]=0x18, [127:96]=0x1C.
- R3: With `lc_msg_we` high, `lc_msg_wdata` is written to the word chosen by `lc_msg_sel` (0..3, in the same order as R2). If the host writes the same word in the same cycle, the local value is kept. A host write to a different word in that cycle still takes effect.
- R4: A host write to the inbound doorbell (0x20) sets each bit written as 1 and leaves each bit written as 0 unchanged. The result appears on `lc_ibell` the cycle after the write, and reads back at 0x20.
- R5: Each 1 in the `lc_ibell_clr` strobe clears the matching inbound doorbell bit. If a host set and a local clear of the same bit happen in the same cycle, the bit ends up set.
- R6: The inbound status register (0x24) reads the inbound doorbell ANDed with the inverse of the inbound mask (0x28, read/write). `lc_irq` is the OR of those status bits.
- R7: Each 1 in `lc_obell_set` sets the matching outbound doorbell bit (0x2C). A host write to 0x2C clears each bit written as 1 and leaves the others unchanged. If a local set and a host clear of the same bit happen in the same cycle, the bit ends up set.
- R8: The outbound status register (0x30) reads the outbound doorbell ANDed with the inverse of the outbound mask (0x3C, read/write). `host_irq` is the OR of those status bits, and it rises the cycle after an unmasked bit is set.
- R9: The doorbell, status and mask registers hold only NBELL bits, and their upper read bits are zero. An outbound doorbell read therefore never returns all ones, and a zero read means no event is pending.
- R10: Reads of any unmapped offset return zero. Host writes to unmapped offsets, and to the two status registers, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_re | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after `h_re` |
| host_irq | output | 1 | OR of unmasked outbound doorbell bits |
| lc_msg_we | input | 1 | Local mailbox write strobe |
| lc_msg_sel | input | 2 | Local mailbox word select |
| lc_msg_wdata | input | 32 | Local mailbox write data |
| lc_msg_rdata | output | 128 | All four mailbox words |
| lc_ibell | output | NBELL | Inbound doorbell bits |
| lc_ibell_clr | input | NBELL | One-cycle clear strobe for inbound bits |
| lc_irq | output | 1 | OR of unmasked inbound doorbell bits |
| lc_obell_set | input | NBELL | One-cycle set strobe for outbound bits |

## Verification
A doorbell bit that is stuck or lost shows up on `lc_ibell`, `lc_irq` or `host_irq` in the cycle right after the write or strobe that should have changed it. The bench checks those outputs at that point. A bad read mux or a wrong mask bit shows on `h_rdata` one cycle after the read strobe. A scoreboard compares every read against an expected value built from the requirements. Same-cycle collisions are driven on purpose, because a wrong priority there would only show as a silently lost event: host against local on one mailbox word, set against clear on each doorbell. Writes to unmapped offsets are each followed by read-back of the real registers.

// File: rtl/hmr_pkg.sv
package hmr_pkg;

    localparam int DATA_W    = 32;
    localparam int MSG_COUNT = 4;
    localparam int MSG_SEL_W = $clog2(MSG_COUNT);

    // word offsets (byte offset >> 2) of the mapped registers
    localparam logic [5:0] WOFF_IMSG0 = 6'h04;
    localparam logic [5:0] WOFF_IMSG1 = 6'h05;
    localparam logic [5:0] WOFF_OMSG0 = 6'h06;
    localparam logic [5:0] WOFF_OMSG1 = 6'h07;
    localparam logic [5:0] WOFF_IBELL = 6'h08;
    localparam logic [5:0] WOFF_ISTAT = 6'h09;
    localparam logic [5:0] WOFF_IMASK = 6'h0A;
    localparam logic [5:0] WOFF_OBELL = 6'h0B;
    localparam logic [5:0] WOFF_OSTAT = 6'h0C;
    localparam logic [5:0] WOFF_OMASK = 6'h0F;

    // inbound doorbell bit meanings
    localparam int IB_HANDSHAKE = 0;
    localparam int IB_REQ_HEAD  = 1;
    localparam int IB_STS_TAIL  = 2;
    localparam int IB_HOST_STOP = 3;
    localparam int IB_RESET     = 4;

    // outbound doorbell bit meanings
    localparam int OB_HANDSHAKE = 0;
    localparam int OB_REQ_TAIL  = 1;
    localparam int OB_STS_HEAD  = 2;
    localparam int OB_BUS_CHG   = 3;
    localparam int OB_EVENT     = 4;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_IMSG0,
        RID_IMSG1,
        RID_OMSG0,
        RID_OMSG1,
        RID_IBELL,
        RID_ISTAT,
        RID_IMASK,
        RID_OBELL,
        RID_OSTAT,
        RID_OMASK
    } reg_id_e;

    typedef struct packed {
        logic              we;
        logic              re;
        reg_id_e           rid;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    function automatic reg_id_e decode_word(input logic [5:0] woff);
        reg_id_e r;
        case (woff)
            WOFF_IMSG0: r = RID_IMSG0;
            WOFF_IMSG1: r = RID_IMSG1;
            WOFF_OMSG0: r = RID_OMSG0;
            WOFF_OMSG1: r = RID_OMSG1;
            WOFF_IBELL: r = RID_IBELL;
            WOFF_ISTAT: r = RID_ISTAT;
            WOFF_IMASK: r = RID_IMASK;
            WOFF_OBELL: r = RID_OBELL;
            WOFF_OSTAT: r = RID_OSTAT;
            WOFF_OMASK: r = RID_OMASK;
            default:    r = RID_NONE;
        endcase
        return r;
    endfunction

    function automatic logic is_msg(input reg_id_e r);
        return (r == RID_IMSG0) || (r == RID_IMSG1) ||
               (r == RID_OMSG0) || (r == RID_OMSG1);
    endfunction

    function automatic logic [MSG_SEL_W-1:0] msg_slot(input reg_id_e r);
        logic [MSG_SEL_W-1:0] s;
        case (r)
            RID_IMSG1: s = MSG_SEL_W'(1);
            RID_OMSG0: s = MSG_SEL_W'(2);
            RID_OMSG1: s = MSG_SEL_W'(3);
            default:   s = MSG_SEL_W'(0);
        endcase
        return s;
    endfunction

    function automatic logic is_narrow(input reg_id_e r);
        return (r == RID_IBELL) || (r == RID_ISTAT) || (r == RID_IMASK) ||
               (r == RID_OBELL) || (r == RID_OSTAT) || (r == RID_OMASK);
    endfunction

endpackage

// File: rtl/hmr_bell.sv
module hmr_bell #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_i) | set_i;
        end
    end

    // R4 / R7: a requested set is visible next cycle, even against a clear (R5)
    a_r5_set_dominates: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

    // R5 / R7: a clear with no competing set empties the bit
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((q & $past(clr_i & ~set_i)) == '0));

    // R4: untouched bits keep their value
    a_r4_untouched_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~$past(set_i | clr_i)) == ($past(q) & ~$past(set_i | clr_i))));

endmodule

// File: rtl/hmr_msg_bank.sv
module hmr_msg_bank
    import hmr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [MSG_COUNT-1:0]             h_we,
    input  logic [DATA_W-1:0]                h_wdata,
    input  logic                             lc_we,
    input  logic [MSG_SEL_W-1:0]             lc_sel,
    input  logic [DATA_W-1:0]                lc_wdata,
    output logic [MSG_COUNT-1:0][DATA_W-1:0] q
);

    for (genvar i = 0; i < MSG_COUNT; i++) begin : g_word
        logic lc_hit;
        assign lc_hit = lc_we && (lc_sel == MSG_SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (lc_hit) begin
                q[i] <= lc_wdata;
            end else if (h_we[i]) begin
                q[i] <= h_wdata;
            end
        end

        // R2: a word with no writer holds its value
        a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
            (!h_we[i] && !lc_hit) |=> $stable(q[i]));

        // R2: a lone host write lands
        a_r2_host_lands: assert property (@(posedge clk) disable iff (rst)
            (h_we[i] && !lc_hit) |=> (q[i] == $past(h_wdata)));
    end

    // R3: the local write always lands, whatever the host does
    a_r3_local_wins: assert property (@(posedge clk) disable iff (rst)
        lc_we |=> (q[$past(lc_sel)] == $past(lc_wdata)));

endmodule

// File: rtl/hmr_host_port.sv
module hmr_host_port
    import hmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBELL  = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             h_we,
    input  logic                             h_re,
    input  logic [ADDR_W-1:0]                h_addr,
    input  logic [DATA_W-1:0]                h_wdata,
    input  logic [MSG_COUNT-1:0][DATA_W-1:0] msg_q,
    input  logic [NBELL-1:0]                 ibell_q,
    input  logic [NBELL-1:0]                 istat,
    input  logic [NBELL-1:0]                 imask_q,
    input  logic [NBELL-1:0]                 obell_q,
    input  logic [NBELL-1:0]                 ostat,
    input  logic [NBELL-1:0]                 omask_q,
    output host_req_t                        req,
    output logic [MSG_COUNT-1:0]             msg_we,
    output logic [NBELL-1:0]                 ibell_set,
    output logic [NBELL-1:0]                 obell_clr,
    output logic                             imask_we,
    output logic                             omask_we,
    output logic [DATA_W-1:0]                h_rdata
);

    localparam int PAD_W = DATA_W - NBELL;

    logic    in_window;
    reg_id_e rid_raw;

    if (ADDR_W > 8) begin : g_wide
        assign in_window = ~|h_addr[ADDR_W-1:8];
    end else begin : g_narrow
        assign in_window = 1'b1;
    end

    assign rid_raw   = decode_word(h_addr[7:2]);
    assign req.we    = h_we;
    assign req.re    = h_re;
    assign req.rid   = in_window ? rid_raw : RID_NONE;
    assign req.wdata = h_wdata;

    for (genvar i = 0; i < MSG_COUNT; i++) begin : g_mwe
        assign msg_we[i] = req.we && is_msg(req.rid) &&
                           (msg_slot(req.rid) == MSG_SEL_W'(i));
    end

    assign ibell_set = (req.we && req.rid == RID_IBELL) ? req.wdata[NBELL-1:0] : '0;
    assign obell_clr = (req.we && req.rid == RID_OBELL) ? req.wdata[NBELL-1:0] : '0;
    assign imask_we  = req.we && (req.rid == RID_IMASK);
    assign omask_we  = req.we && (req.rid == RID_OMASK);

    function automatic logic [DATA_W-1:0] widen(input logic [NBELL-1:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (req.rid)
            RID_IMSG0, RID_IMSG1,
            RID_OMSG0, RID_OMSG1: rd_mux = msg_q[msg_slot(req.rid)];
            RID_IBELL:            rd_mux = widen(ibell_q);
            RID_ISTAT:            rd_mux = widen(istat);
            RID_IMASK:            rd_mux = widen(imask_q);
            RID_OBELL:            rd_mux = widen(obell_q);
            RID_OSTAT:            rd_mux = widen(ostat);
            RID_OMASK:            rd_mux = widen(omask_q);
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
        end else if (req.re) begin
            h_rdata <= rd_mux;
        end
    end

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req.re && req.rid == RID_NONE) |=> (h_rdata == '0));

    // R9: narrow registers never show upper bits
    a_r9_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (req.re && is_narrow(req.rid)) |=> (h_rdata[DATA_W-1:NBELL] == '0));

    // R2: read data holds between read strobes
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !req.re |=> $stable(h_rdata));

endmodule

// File: rtl/hostmsg_regfile.sv
module hostmsg_regfile #(
    parameter int ADDR_W = 8,
    parameter int NBELL  = 5
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           h_we,
    input  logic                                           h_re,
    input  logic [ADDR_W-1:0]                              h_addr,
    input  logic [hmr_pkg::DATA_W-1:0]                     h_wdata,
    output logic [hmr_pkg::DATA_W-1:0]                     h_rdata,
    output logic                                           host_irq,
    input  logic                                           lc_msg_we,
    input  logic [hmr_pkg::MSG_SEL_W-1:0]                  lc_msg_sel,
    input  logic [hmr_pkg::DATA_W-1:0]                     lc_msg_wdata,
    output logic [hmr_pkg::MSG_COUNT*hmr_pkg::DATA_W-1:0]  lc_msg_rdata,
    output logic [NBELL-1:0]                               lc_ibell,
    input  logic [NBELL-1:0]                               lc_ibell_clr,
    output logic                                           lc_irq,
    input  logic [NBELL-1:0]                               lc_obell_set
);
    import hmr_pkg::*;

    logic [MSG_COUNT-1:0][DATA_W-1:0] msg_q;
    logic [MSG_COUNT-1:0]             msg_we;
    logic [NBELL-1:0]                 ibell_q, obell_q;
    logic [NBELL-1:0]                 ibell_set, obell_clr;
    logic [NBELL-1:0]                 imask_q, omask_q;
    logic [NBELL-1:0]                 istat, ostat;
    logic                             imask_we, omask_we;
    host_req_t                        req;

    hmr_host_port #(.ADDR_W(ADDR_W), .NBELL(NBELL)) u_port (
        .clk       (clk),
        .rst       (rst),
        .h_we      (h_we),
        .h_re      (h_re),
        .h_addr    (h_addr),
        .h_wdata   (h_wdata),
        .msg_q     (msg_q),
        .ibell_q   (ibell_q),
        .istat     (istat),
        .imask_q   (imask_q),
        .obell_q   (obell_q),
        .ostat     (ostat),
        .omask_q   (omask_q),
        .req       (req),
        .msg_we    (msg_we),
        .ibell_set (ibell_set),
        .obell_clr (obell_clr),
        .imask_we  (imask_we),
        .omask_we  (omask_we),
        .h_rdata   (h_rdata)
    );

    hmr_msg_bank u_msgs (
        .clk      (clk),
        .rst      (rst),
        .h_we     (msg_we),
        .h_wdata  (req.wdata),
        .lc_we    (lc_msg_we),
        .lc_sel   (lc_msg_sel),
        .lc_wdata (lc_msg_wdata),
        .q        (msg_q)
    );

    // inbound: host sets, local clears
    hmr_bell #(.W(NBELL)) u_ibell (
        .clk   (clk),
        .rst   (rst),
        .set_i (ibell_set),
        .clr_i (lc_ibell_clr),
        .q     (ibell_q)
    );

    // outbound: local sets, host clears
    hmr_bell #(.W(NBELL)) u_obell (
        .clk   (clk),
        .rst   (rst),
        .set_i (lc_obell_set),
        .clr_i (obell_clr),
        .q     (obell_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            imask_q <= '1;
            omask_q <= '1;
        end else begin
            if (imask_we) imask_q <= req.wdata[NBELL-1:0];
            if (omask_we) omask_q <= req.wdata[NBELL-1:0];
        end
    end

    assign istat        = ibell_q & ~imask_q;
    assign ostat        = obell_q & ~omask_q;
    assign lc_irq       = |istat;
    assign host_irq     = |ostat;
    assign lc_ibell     = ibell_q;
    assign lc_msg_rdata = msg_q;

    // R8: an unmasked local event raises the host line next cycle
    a_r8_irq_follows_event: assert property (@(posedge clk) disable iff (rst)
        (!h_we && |(lc_obell_set & ~omask_q)) |=> host_irq);

    // R6: an unmasked inbound bit keeps the local line up
    a_r6_local_irq_held: assert property (@(posedge clk) disable iff (rst)
        (!h_we && lc_ibell_clr == '0 && |(ibell_q & ~imask_q)) |=> lc_irq);

    // R10: writes to unmapped or read-only offsets change nothing
    a_r10_inert_write: assert property (@(posedge clk) disable iff (rst)
        (h_we && (req.rid == RID_NONE || req.rid == RID_ISTAT || req.rid == RID_OSTAT) &&
         !lc_msg_we && lc_ibell_clr == '0 && lc_obell_set == '0)
        |=> ($stable(msg_q) && $stable(ibell_q) && $stable(obell_q) &&
             $stable(imask_q) && $stable(omask_q)));

    // R1: out of reset nothing requests service
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!host_irq && !lc_irq && lc_ibell == '0));

endmodule

// File: tb/hostmsg_regfile_test.sv
`timescale 1ns/1ps
module hostmsg_regfile_test;

    localparam int NB = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         h_we = 1'b0;
    logic         h_re = 1'b0;
    logic [7:0]   h_addr = '0;
    logic [31:0]  h_wdata = '0;
    logic [31:0]  h_rdata;
    logic         host_irq;
    logic         lc_msg_we = 1'b0;
    logic [1:0]   lc_msg_sel = '0;
    logic [31:0]  lc_msg_wdata = '0;
    logic [127:0] lc_msg_rdata;
    logic [NB-1:0] lc_ibell;
    logic [NB-1:0] lc_ibell_clr = '0;
    logic          lc_irq;
    logic [NB-1:0] lc_obell_set = '0;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mon_exp;
    string       mon_tag;

    always #2 clk = ~clk;

    hostmsg_regfile #(.ADDR_W(8), .NBELL(NB)) uut (
        .clk          (clk),
        .rst          (rst),
        .h_we         (h_we),
        .h_re         (h_re),
        .h_addr       (h_addr),
        .h_wdata      (h_wdata),
        .h_rdata      (h_rdata),
        .host_irq     (host_irq),
        .lc_msg_we    (lc_msg_we),
        .lc_msg_sel   (lc_msg_sel),
        .lc_msg_wdata (lc_msg_wdata),
        .lc_msg_rdata (lc_msg_rdata),
        .lc_ibell     (lc_ibell),
        .lc_ibell_clr (lc_ibell_clr),
        .lc_irq       (lc_irq),
        .lc_obell_set (lc_obell_set)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // read monitor: data is due one cycle after the strobe edge
    always @(posedge clk) begin
        if (h_re && !rst) begin
            #1;
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            chk(mon_tag, {96'd0, h_rdata}, {96'd0, mon_exp});
        end
    end

    task automatic tick();
        @(negedge clk);
        h_we         = 1'b0;
        h_re         = 1'b0;
        lc_msg_we    = 1'b0;
        lc_ibell_clr = '0;
        lc_obell_set = '0;
    endtask

    task automatic set_wr(input logic [7:0] a, input logic [31:0] d);
        h_we = 1'b1; h_addr = a; h_wdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        set_wr(a, d);
        tick();
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        h_re = 1'b1; h_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tick();
    endtask

    task automatic set_lmsg(input logic [1:0] s, input logic [31:0] d);
        lc_msg_we = 1'b1; lc_msg_sel = s; lc_msg_wdata = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_irq", {127'd0, host_irq}, 128'd0);
        chk("R1 lc_irq", {127'd0, lc_irq}, 128'd0);
        chk("R1 lc_ibell", {123'd0, lc_ibell}, 128'd0);
        chk("R1 lc_msg_rdata", lc_msg_rdata, 128'd0);
        rd(8'h10, 32'h0, "R1 msg0");
        rd(8'h1C, 32'h0, "R1 msg3");
        rd(8'h20, 32'h0, "R1 ibell");
        rd(8'h28, 32'h1F, "R1 imask");
        rd(8'h2C, 32'h0, "R1 obell");
        rd(8'h3C, 32'h1F, "R1 omask");
        rd(8'h24, 32'h0, "R1 istat");
        rd(8'h30, 32'h0, "R1 ostat");

        // R2 host mailbox access, read right after write
        wr(8'h10, 32'hA5A5_0001); rd(8'h10, 32'hA5A5_0001, "R2 msg0");
        wr(8'h14, 32'h0BAD_F00D); rd(8'h14, 32'h0BAD_F00D, "R2 msg1");
        wr(8'h18, 32'h1234_5678); rd(8'h18, 32'h1234_5678, "R2 msg2");
        wr(8'h1F, 32'hCAFE_0003); rd(8'h1C, 32'hCAFE_0003, "R2 msg3 low addr bits");
        chk("R2 lc_msg_rdata", lc_msg_rdata,
            {32'hCAFE_0003, 32'h1234_5678, 32'h0BAD_F00D, 32'hA5A5_0001});

        // R3 local writes and collisions
        set_lmsg(2'd2, 32'hDEAD_BEEF); tick();
        rd(8'h18, 32'hDEAD_BEEF, "R3 local write");
        set_wr(8'h1C, 32'h1111_1111); set_lmsg(2'd3, 32'h2222_2222); tick();
        rd(8'h1C, 32'h2222_2222, "R3 local wins collision");
        set_wr(8'h10, 32'h3333_3333); set_lmsg(2'd1, 32'h4444_4444); tick();
        rd(8'h10, 32'h3333_3333, "R3 host other word");
        rd(8'h14, 32'h4444_4444, "R3 local other word");

        // R4 inbound set
        wr(8'h20, 32'h02);
        chk("R4 set bit1", {123'd0, lc_ibell}, 128'h02);
        wr(8'h20, 32'h05);
        chk("R4 ones set zeros keep", {123'd0, lc_ibell}, 128'h07);
        wr(8'h20, 32'h00);
        chk("R4 zero write", {123'd0, lc_ibell}, 128'h07);
        rd(8'h20, 32'h07, "R4 readback");

        // R6 inbound mask and status
        chk("R6 all masked", {127'd0, lc_irq}, 128'd0);
        rd(8'h24, 32'h0, "R6 istat masked");
        wr(8'h28, 32'h04);
        rd(8'h24, 32'h03, "R6 istat partial");
        chk("R6 lc_irq", {127'd0, lc_irq}, 128'd1);

        // R5 local clear and collision
        lc_ibell_clr = 5'h01; tick();
        chk("R5 clear", {123'd0, lc_ibell}, 128'h06);
        set_wr(8'h20, 32'h08); lc_ibell_clr = 5'h0A; tick();
        chk("R5 set beats clear", {123'd0, lc_ibell}, 128'h0C);
        lc_ibell_clr = 5'h1F; tick();
        chk("R5 clear all", {123'd0, lc_ibell}, 128'h00);
        chk("R6 lc_irq drop", {127'd0, lc_irq}, 128'd0);

        // R7 / R8 outbound
        lc_obell_set = 5'h04; tick();
        rd(8'h2C, 32'h04, "R7 local set");
        chk("R8 masked no irq", {127'd0, host_irq}, 128'd0);
        wr(8'h3C, 32'h1B);
        chk("R8 unmask irq", {127'd0, host_irq}, 128'd1);
        rd(8'h30, 32'h04, "R8 ostat");
        lc_obell_set = 5'h10; tick();
        rd(8'h2C, 32'h14, "R7 second set");
        rd(8'h30, 32'h04, "R8 ostat masked bit4");
        wr(8'h2C, 32'h01);
        rd(8'h2C, 32'h14, "R7 clear of clear bit");
        wr(8'h2C, 32'h04);
        rd(8'h2C, 32'h10, "R7 w1c");
        chk("R8 irq drop", {127'd0, host_irq}, 128'd0);
        set_wr(8'h2C, 32'h14); lc_obell_set = 5'h04; tick();
        chk("R8 irq after collision", {127'd0, host_irq}, 128'd1);
        rd(8'h2C, 32'h04, "R7 set beats clear");
        wr(8'h2C, 32'h04);
        rd(8'h2C, 32'h00, "R9 zero means idle");
        lc_obell_set = 5'h04; tick();
        chk("R8 irq one cycle after set", {127'd0, host_irq}, 128'd1);
        wr(8'h2C, 32'h04);

        // R9 width limits
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, 32'h1F, "R9 mask width");
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h1F, "R9 ibell width");
        lc_obell_set = 5'h1F; tick();
        rd(8'h2C, 32'h1F, "R9 obell never all ones");

        // R10 unmapped and read-only offsets
        wr(8'h28, 32'h0);
        rd(8'h24, 32'h1F, "R10 istat before");
        wr(8'h24, 32'h0);
        rd(8'h24, 32'h1F, "R10 istat read-only");
        wr(8'h30, 32'h0);
        rd(8'h2C, 32'h1F, "R10 ostat write ignored");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R10 read 0x00");
        rd(8'h34, 32'h0, "R10 read 0x34");
        rd(8'h38, 32'h0, "R10 read 0x38");
        rd(8'h80, 32'h0, "R10 read 0x80");
        rd(8'h10, 32'h3333_3333, "R10 msg0 intact");
        rd(8'h14, 32'h4444_4444, "R10 msg1 intact");
        rd(8'h3C, 32'h1B, "R10 omask intact");
        rd(8'h28, 32'h00, "R10 imask intact");

        tick();
        tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule